// File: doc/BRIEF.md
# Graphics Masked Block-Write Datapath

This block is the write-data path of a 32-bit graphics memory. Each write command is merged with four byte-lane masks and, when requested, with a persistent per-bit mask register. The result is a set of per-column write enables, a bit-enable vector and a data word. These outputs are registered and then applied to a small behavioural column array, which has a combinational read port for observation.

Two registers live inside the block: a bit mask and a colour word. A load command with the function-select input high writes one of them. A write command with function-select high becomes a block write. A block write stores the colour word into up to eight adjacent, aligned columns in a single clock. The low byte of the data bus chooses which of those columns are written.

Top module: `gfx_wrpath`

## Requirements
- R1: While reset is low and after it, the mask register reads all ones, the colour register reads zero, col_we, bit_en, wr_word and blk_base are zero, and every array word reads zero.
- R2: A load (cmd = 2) with fsel = 1 writes wdata into the mask register when col_addr[0] = 0, or into the colour register when col_addr[0] = 1. The new value is visible on mask_out or color_out after the next rising edge.
- R3: A load (cmd = 2) with fsel = 0 changes neither the mask register nor the colour register.
- R4: A normal write (cmd = 1, fsel = 0) produces, one clock later, a col_we with exactly bit col_addr[2:0] set. In the same cycle, blk_base equals col_addr[COL_W-1:3] and wr_word equals wdata.
- R5: During a write, bmask[i] = 1 clears bit_en bits 8i+7 down to 8i, and bmask[i] = 0 leaves that lane enabled.
- R6: With wpb = 1, bit_en is the byte-lane enable ANDed with the mask register. With wpb = 0, the mask register has no effect on bit_en.
- R7: A block write (cmd = 1, fsel = 1) ignores col_addr[2:0]. One clock later it gives col_we = wdata[7:0], blk_base = col_addr[COL_W-1:3] and wr_word = the colour register.
- R8: On the rising edge after col_we, bit_en and wr_word appear, the array word at {blk_base, c} is updated for every set bit c of col_we. Within each such word, only the bits set in bit_en change. Words whose column bit is clear are unchanged.
- R9: A command of 0 (idle) or 3 (reserved) gives col_we, bit_en, wr_word and blk_base all zero one clock later.
- R10: The mask and colour registers hold their values across every command other than a load with fsel = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 2 | Command: 0 idle, 1 write, 2 load, 3 reserved |
| fsel | input | 1 | Function select: block write on write, register load on load |
| wpb | input | 1 | Enables per-bit masking from the mask register for this write |
| col_addr | input | COL_W | Column address; bit 0 picks the register on a load |
| bmask | input | DATA_W/8 | Per-lane byte mask, 1 suppresses the lane |
| wdata | input | DATA_W | Write data, register load value, or block column enables in bits 7:0 |
| rd_addr | input | COL_W | Array read address |
| col_we | output | BLK_COLS | Registered per-column write enables within the group |
| blk_base | output | COL_W-3 | Registered group address of the targeted columns |
| bit_en | output | DATA_W | Registered bit-enable vector |
| wr_word | output | DATA_W | Registered data to store |
| mask_out | output | DATA_W | Current mask register |
| color_out | output | DATA_W | Current colour register |
| rd_data | output | DATA_W | Array word at rd_addr, combinational |

## Verification
The bench builds the block with DATA_W = 32, COL_W = 6 and BLK_COLS = 8. This gives a 64-word array in eight aligned groups, so every column the vectors touch can be read back afterwards. At this size a block write into a group that already holds a normally written word is reachable, and the bench reads that word to confirm that unselected columns are left alone. With a 32-bit word, all four byte lanes and a sparse mask pattern interact in one command, which separates byte masking from per-bit masking.

// File: rtl/gfx_wr_pkg.sv
`timescale 1ns/1ps
package gfx_wr_pkg;
    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_LOAD  = 2'd2,
        CMD_RSVD  = 2'd3
    } cmd_e;
endpackage

// File: rtl/gfx_wr_regs.sv
`timescale 1ns/1ps
module gfx_wr_regs
    import gfx_wr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd_i,
    input  logic              fsel_i,
    input  logic              pick_color_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] mask_o,
    output logic [DATA_W-1:0] color_o
);
    typedef struct packed {
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] color;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (cmd_i == CMD_LOAD && fsel_i) begin
            if (pick_color_i) regs_d.color = wdata_i;
            else              regs_d.mask  = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.mask  <= '1;
            regs_q.color <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign mask_o  = regs_q.mask;
    assign color_o = regs_q.color;
endmodule

// File: rtl/gfx_wr_merge.sv
`timescale 1ns/1ps
module gfx_wr_merge
    import gfx_wr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int COL_W    = 6,
    parameter int BLK_COLS = 8
) (
    input  logic [1:0]                            cmd_i,
    input  logic                                  fsel_i,
    input  logic                                  wpb_i,
    input  logic [COL_W-1:0]                      addr_i,
    input  logic [DATA_W/8-1:0]                   bmask_i,
    input  logic [DATA_W-1:0]                     wdata_i,
    input  logic [DATA_W-1:0]                     mask_i,
    input  logic [DATA_W-1:0]                     color_i,
    output logic [BLK_COLS-1:0]                   we_o,
    output logic [COL_W-$clog2(BLK_COLS)-1:0]     base_o,
    output logic [DATA_W-1:0]                     ben_o,
    output logic [DATA_W-1:0]                     word_o
);
    localparam int LANES = DATA_W / 8;
    localparam int SEL_W = $clog2(BLK_COLS);

    logic [DATA_W-1:0] lane_en;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_en[g*8 +: 8] = {8{~bmask_i[g]}};
    end

    always_comb begin
        we_o   = '0;
        base_o = '0;
        ben_o  = '0;
        word_o = '0;
        if (cmd_i == CMD_WRITE) begin
            base_o = addr_i[COL_W-1:SEL_W];
            ben_o  = wpb_i ? (lane_en & mask_i) : lane_en;
            if (fsel_i) begin
                we_o   = wdata_i[BLK_COLS-1:0];
                word_o = color_i;
            end else begin
                we_o   = BLK_COLS'(1) << addr_i[SEL_W-1:0];
                word_o = wdata_i;
            end
        end
    end
endmodule

// File: rtl/gfx_col_array.sv
`timescale 1ns/1ps
module gfx_col_array #(
    parameter int DATA_W   = 32,
    parameter int COL_W    = 6,
    parameter int BLK_COLS = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [BLK_COLS-1:0]                   we_i,
    input  logic [COL_W-$clog2(BLK_COLS)-1:0]     base_i,
    input  logic [DATA_W-1:0]                     ben_i,
    input  logic [DATA_W-1:0]                     word_i,
    input  logic [COL_W-1:0]                      rd_addr_i,
    output logic [DATA_W-1:0]                     rd_data_o
);
    localparam int SEL_W = $clog2(BLK_COLS);
    localparam int DEPTH = 1 << COL_W;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        for (int c = 0; c < BLK_COLS; c++) begin
            if (we_i[c]) begin
                mem_d[{base_i, SEL_W'(c)}] =
                    (mem_q[{base_i, SEL_W'(c)}] & ~ben_i) | (word_i & ben_i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/gfx_wrpath.sv
`timescale 1ns/1ps
module gfx_wrpath #(
    parameter int DATA_W   = 32,
    parameter int COL_W    = 6,
    parameter int BLK_COLS = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [1:0]                            cmd,
    input  logic                                  fsel,
    input  logic                                  wpb,
    input  logic [COL_W-1:0]                      col_addr,
    input  logic [DATA_W/8-1:0]                   bmask,
    input  logic [DATA_W-1:0]                     wdata,
    input  logic [COL_W-1:0]                      rd_addr,
    output logic [BLK_COLS-1:0]                   col_we,
    output logic [COL_W-$clog2(BLK_COLS)-1:0]     blk_base,
    output logic [DATA_W-1:0]                     bit_en,
    output logic [DATA_W-1:0]                     wr_word,
    output logic [DATA_W-1:0]                     mask_out,
    output logic [DATA_W-1:0]                     color_out,
    output logic [DATA_W-1:0]                     rd_data
);
    localparam int SEL_W  = $clog2(BLK_COLS);
    localparam int BASE_W = COL_W - SEL_W;

    typedef struct packed {
        logic [BLK_COLS-1:0] we;
        logic [BASE_W-1:0]   base;
        logic [DATA_W-1:0]   ben;
        logic [DATA_W-1:0]   word;
    } wr_out_t;

    logic [BLK_COLS-1:0] m_we;
    logic [BASE_W-1:0]   m_base;
    logic [DATA_W-1:0]   m_ben;
    logic [DATA_W-1:0]   m_word;
    wr_out_t             out_d, out_q;

    gfx_wr_regs #(.DATA_W(DATA_W)) regs_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_i        (cmd),
        .fsel_i       (fsel),
        .pick_color_i (col_addr[0]),
        .wdata_i      (wdata),
        .mask_o       (mask_out),
        .color_o      (color_out)
    );

    gfx_wr_merge #(.DATA_W(DATA_W), .COL_W(COL_W), .BLK_COLS(BLK_COLS)) merge_i (
        .cmd_i   (cmd),
        .fsel_i  (fsel),
        .wpb_i   (wpb),
        .addr_i  (col_addr),
        .bmask_i (bmask),
        .wdata_i (wdata),
        .mask_i  (mask_out),
        .color_i (color_out),
        .we_o    (m_we),
        .base_o  (m_base),
        .ben_o   (m_ben),
        .word_o  (m_word)
    );

    always_comb begin
        out_d.we   = m_we;
        out_d.base = m_base;
        out_d.ben  = m_ben;
        out_d.word = m_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign col_we   = out_q.we;
    assign blk_base = out_q.base;
    assign bit_en   = out_q.ben;
    assign wr_word  = out_q.word;

    gfx_col_array #(.DATA_W(DATA_W), .COL_W(COL_W), .BLK_COLS(BLK_COLS)) array_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (out_q.we),
        .base_i    (out_q.base),
        .ben_i     (out_q.ben),
        .word_i    (out_q.word),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );
endmodule

// File: rtl/gfx_wrpath_chk.sv
`timescale 1ns/1ps
module gfx_wrpath_chk
    import gfx_wr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int BLK_COLS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [1:0]            cmd,
    input logic                  fsel,
    input logic                  wpb,
    input logic [DATA_W/8-1:0]   bmask,
    input logic [BLK_COLS-1:0]   col_we,
    input logic [DATA_W-1:0]     bit_en,
    input logic [DATA_W-1:0]     wr_word,
    input logic [DATA_W-1:0]     mask_out,
    input logic [DATA_W-1:0]     color_out
);
    logic live_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    AST_NORMAL_ONE_COL: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(cmd == CMD_WRITE && !fsel) |-> $countones(col_we) == 1); // R4

    AST_BLOCK_COLOR: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(cmd == CMD_WRITE && fsel) |-> wr_word == color_out); // R7

    AST_PERBIT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(cmd == CMD_WRITE && wpb) |-> (bit_en & ~mask_out) == '0); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(cmd != CMD_WRITE) |-> col_we == '0 && bit_en == '0); // R9

    AST_PLAIN_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(cmd == CMD_LOAD && !fsel) |-> $stable(mask_out) && $stable(color_out)); // R3

    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(cmd != CMD_LOAD) |-> $stable(mask_out) && $stable(color_out)); // R10

    for (genvar g = 0; g < DATA_W/8; g++) begin : g_lane_chk
        AST_LANE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            live_q && $past(cmd == CMD_WRITE && bmask[g]) |-> bit_en[g*8 +: 8] == 8'h00); // R5
    end
endmodule

bind gfx_wrpath gfx_wrpath_chk #(.DATA_W(DATA_W), .BLK_COLS(BLK_COLS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .fsel      (fsel),
    .wpb       (wpb),
    .bmask     (bmask),
    .col_we    (col_we),
    .bit_en    (bit_en),
    .wr_word   (wr_word),
    .mask_out  (mask_out),
    .color_out (color_out)
);

// File: tb/gfx_wrpath_tb_top.sv
`timescale 1ns/1ps
module gfx_wrpath_tb_top;
    localparam int DATA_W   = 32;
    localparam int COL_W    = 6;
    localparam int BLK_COLS = 8;

    typedef struct packed {
        logic [1:0]  cmd;
        logic        fsel;
        logic        wpb;
        logic [5:0]  addr;
        logic [3:0]  bm;
        logic [31:0] wd;
        logic [7:0]  we;
        logic [2:0]  base;
        logic [31:0] ben;
        logic [31:0] word;
        logic [31:0] mask;
        logic [31:0] color;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{2'd1,1'b0,1'b0,6'd13,4'h0,32'hDEADBEEF,8'h20,3'd1,32'hFFFFFFFF,32'hDEADBEEF,32'hFFFFFFFF,32'h00000000},
        '{2'd1,1'b0,1'b0,6'd2, 4'h5,32'h12345678,8'h04,3'd0,32'hFF00FF00,32'h12345678,32'hFFFFFFFF,32'h00000000},
        '{2'd2,1'b1,1'b0,6'd0, 4'h0,32'h0F0F00FF,8'h00,3'd0,32'h00000000,32'h00000000,32'h0F0F00FF,32'h00000000},
        '{2'd2,1'b1,1'b0,6'd1, 4'h0,32'hCAFEF00D,8'h00,3'd0,32'h00000000,32'h00000000,32'h0F0F00FF,32'hCAFEF00D},
        '{2'd2,1'b0,1'b0,6'd0, 4'h0,32'h00000000,8'h00,3'd0,32'h00000000,32'h00000000,32'h0F0F00FF,32'hCAFEF00D},
        '{2'd1,1'b0,1'b1,6'd7, 4'h0,32'hAAAAAAAA,8'h80,3'd0,32'h0F0F00FF,32'hAAAAAAAA,32'h0F0F00FF,32'hCAFEF00D},
        '{2'd1,1'b0,1'b0,6'd0, 4'h8,32'h11111111,8'h01,3'd0,32'h00FFFFFF,32'h11111111,32'h0F0F00FF,32'hCAFEF00D},
        '{2'd1,1'b1,1'b0,6'd21,4'h0,32'h000000A5,8'hA5,3'd2,32'hFFFFFFFF,32'hCAFEF00D,32'h0F0F00FF,32'hCAFEF00D},
        '{2'd1,1'b1,1'b1,6'd8, 4'h4,32'hFFFFFF0F,8'h0F,3'd1,32'h0F0000FF,32'hCAFEF00D,32'h0F0F00FF,32'hCAFEF00D},
        '{2'd0,1'b0,1'b0,6'd5, 4'h0,32'hFFFFFFFF,8'h00,3'd0,32'h00000000,32'h00000000,32'h0F0F00FF,32'hCAFEF00D},
        '{2'd3,1'b1,1'b1,6'd9, 4'h0,32'hFFFFFFFF,8'h00,3'd0,32'h00000000,32'h00000000,32'h0F0F00FF,32'hCAFEF00D}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cmd = 2'd0;
    logic              fsel = 1'b0;
    logic              wpb = 1'b0;
    logic [COL_W-1:0]  col_addr = '0;
    logic [3:0]        bmask = '0;
    logic [31:0]       wdata = '0;
    logic [COL_W-1:0]  rd_addr = '0;
    logic [7:0]        col_we;
    logic [2:0]        blk_base;
    logic [31:0]       bit_en, wr_word, mask_out, color_out, rd_data;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    gfx_wrpath #(.DATA_W(DATA_W), .COL_W(COL_W), .BLK_COLS(BLK_COLS)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .fsel(fsel), .wpb(wpb),
        .col_addr(col_addr), .bmask(bmask), .wdata(wdata), .rd_addr(rd_addr),
        .col_we(col_we), .blk_base(blk_base), .bit_en(bit_en), .wr_word(wr_word),
        .mask_out(mask_out), .color_out(color_out), .rd_data(rd_data)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic read_word(input int a, input logic [31:0] exp);
        rd_addr = COL_W'(a);
        #1;
        check($sformatf("R8 array word %0d", a), rd_data, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 mask at reset", mask_out, 32'hFFFFFFFF);
        check("R1 colour at reset", color_out, 32'h0);
        check("R1 col_we at reset", {24'h0, col_we}, 32'h0);
        check("R1 bit_en at reset", bit_en, 32'h0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 wr_word after reset", wr_word, 32'h0);
        read_word(13, 32'h0);

        for (int i = 0; i < NV; i++) begin
            cmd      = VEC[i].cmd;
            fsel     = VEC[i].fsel;
            wpb      = VEC[i].wpb;
            col_addr = VEC[i].addr;
            bmask    = VEC[i].bm;
            wdata    = VEC[i].wd;
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R4 R7 R9 col_we v%0d", i), {24'h0, col_we}, {24'h0, VEC[i].we});
            check($sformatf("R4 R7 blk_base v%0d", i), {29'h0, blk_base}, {29'h0, VEC[i].base});
            check($sformatf("R5 R6 bit_en v%0d", i), bit_en, VEC[i].ben);
            check($sformatf("R4 R7 wr_word v%0d", i), wr_word, VEC[i].word);
            check($sformatf("R2 R3 R10 mask v%0d", i), mask_out, VEC[i].mask);
            check($sformatf("R2 R3 R10 colour v%0d", i), color_out, VEC[i].color);
        end

        cmd = 2'd0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        read_word(13, 32'hDEADBEEF);
        read_word(2,  32'h12005600);
        read_word(7,  32'h0A0A00AA);
        read_word(0,  32'h00111111);
        read_word(16, 32'hCAFEF00D);
        read_word(17, 32'h00000000);
        read_word(21, 32'hCAFEF00D);
        read_word(23, 32'hCAFEF00D);
        read_word(9,  32'h0A00000D);
        read_word(11, 32'h0A00000D);
        read_word(12, 32'h00000000);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule